// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block steers a multithreaded core that runs one thread at a time. The chosen thread issues without interruption, and short hazards are handled elsewhere. When that thread reports a long-latency event, such as a miss in the second-level cache, the controller does five things. It empties the pipeline of the old thread. It records the PC of the missing instruction as the old thread's resume point. It parks the old thread as waiting. It points fetch at the next ready thread, which it finds by a round-robin scan. It then signals a refill interval as long as the pipeline, during which no completions from the new thread can appear.

A per-thread miss-completion input makes a waiting thread eligible again. If no thread is ready after a switch, fetch is turned off until one becomes ready. That thread is then resumed at its saved PC. A long-stall report that arrives during a refill interval is held and acted on once the interval ends.

Top module: `cg_thread_switch`

## Requirements
- R1: After reset, fetch_en is 1, cur_tid is 0, and flush, redirect, refill_busy and switch_count are all 0. Every thread is ready, and its resume PC is RESET_PC.
- R2: A long_stall from the running thread, while refill_busy is low, gives a one-cycle flush on the next cycle and increments switch_count by one. If another thread is ready, that same cycle also shows redirect=1 with cur_tid set to that thread.
- R3: redirect_pc, valid while redirect is 1, is the resume PC of the thread named by cur_tid. That PC is the stall_pc it reported when it was last switched away, or RESET_PC if the thread has never been switched away.
- R4: refill_busy is high for exactly PIPE_DEPTH consecutive cycles. Those cycles begin with the cycle in which redirect is 1, and every switch and every resume from idle starts such an interval.
- R5: A long_stall that arrives while refill_busy is high is held, not dropped. Its flush appears on the cycle after the first cycle in which refill_busy is low.
- R6: The next thread is the first ready thread in the order cur_tid+1, cur_tid+2, and so on, wrapping modulo NT. Waiting threads are skipped.
- R7: If no other thread is ready at a switch, the flush cycle shows redirect=0 and fetch_en=0. Further long_stall inputs have no effect while the core is idle: switch_count and fetch_en do not change.
- R8: While idle, a miss_done pulse for a waiting thread resumes that thread. fetch_en, redirect and cur_tid appear two cycles after the pulse, with no flush and no change to switch_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_stall | input | 1 | Costly stall reported by the running thread |
| stall_pc | input | PC_W | PC of the instruction that missed |
| miss_done | input | NT | Per-thread miss completion |
| fetch_en | output | 1 | A thread is active and fetching |
| cur_tid | output | TID_W | Active thread |
| redirect | output | 1 | One-cycle pulse: fetch restarts at redirect_pc |
| redirect_pc | output | PC_W | Resume PC of the incoming thread |
| flush | output | 1 | One-cycle pulse: discard the outgoing thread's in-flight work |
| refill_busy | output | 1 | Pipeline refill interval in progress |
| switch_count | output | CNT_W | Number of switches away from a thread |

## Verification
The bench injects a stall during a refill interval. A design that dropped the stall would never flush again, and one that acted on it early would flush while refill_busy is still high. It drives the core idle by parking every thread. Wrongly counting resumes, or fetching while nothing is ready, would show up as a wrong switch_count or a high fetch_en. It also wakes threads out of order, so that a scan that does not skip waiting threads, or starts at the wrong position, would pick the wrong thread or return a stale resume PC.

// File: rtl/cg_thread_switch.sv
module cg_thread_switch #(
  parameter int NT = 4,
  parameter int PC_W = 32,
  parameter int PIPE_DEPTH = 5,
  parameter int CNT_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = 'h100,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int RC_W = $clog2(PIPE_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_stall,
  input  logic [PC_W-1:0]  stall_pc,
  input  logic [NT-1:0]    miss_done,
  output logic             fetch_en,
  output logic [TID_W-1:0] cur_tid,
  output logic             redirect,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             flush,
  output logic             refill_busy,
  output logic [CNT_W-1:0] switch_count
);
  logic [NT-1:0]    ready;
  logic [PC_W-1:0]  resume_pc [NT];
  logic [RC_W-1:0]  rcnt;
  logic             pend;
  logic [PC_W-1:0]  pend_pc;
  logic             take, wake, found;
  logic [TID_W-1:0] nxt;
  logic [NT-1:0]    cur_oh, cand;

  assign refill_busy = (rcnt != '0);
  assign take = fetch_en & ~refill_busy & (pend | long_stall);
  assign wake = ~fetch_en & (|ready);
  assign cur_oh = NT'(1) << cur_tid;
  assign cand = ready & ~(take ? cur_oh : '0);

  always_comb begin
    int idx;
    found = 1'b0;
    nxt = cur_tid;
    for (int k = 1; k <= NT; k++) begin
      idx = (int'(cur_tid) + k) % NT;
      if (!found && cand[idx]) begin
        found = 1'b1;
        nxt = TID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_en <= 1'b1;
      cur_tid <= '0;
      ready <= '1;
      for (int i = 0; i < NT; i++) resume_pc[i] <= RESET_PC;
      rcnt <= '0;
      pend <= 1'b0;
      pend_pc <= '0;
      flush <= 1'b0;
      redirect <= 1'b0;
      redirect_pc <= RESET_PC;
      switch_count <= '0;
    end else begin
      flush <= take;
      redirect <= 1'b0;
      ready <= (ready | miss_done) & ~(take ? cur_oh : '0);
      if (refill_busy) rcnt <= rcnt - 1'b1;
      if (fetch_en && long_stall && !take && !pend) begin
        pend <= 1'b1;
        pend_pc <= stall_pc;
      end
      if (take) begin
        pend <= 1'b0;
        resume_pc[cur_tid] <= pend ? pend_pc : stall_pc;
        switch_count <= switch_count + 1'b1;
      end
      if ((take || wake) && found) begin
        cur_tid <= nxt;
        fetch_en <= 1'b1;
        redirect <= 1'b1;
        redirect_pc <= resume_pc[nxt];
        rcnt <= RC_W'(PIPE_DEPTH);
      end else if (take) begin
        fetch_en <= 1'b0;
      end
    end
  end

  // R2
  flush_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> switch_count == $past(switch_count) + 1'b1);

  // R4
  refill_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_busy |-> fetch_en);

  // R4
  refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refill_busy) |-> redirect);

  // R6
  active_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> ready[cur_tid]);

  // R5
  held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && pend && !refill_busy) |=> flush);

  // R7
  idle_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !redirect) |-> !fetch_en);
endmodule

// File: tb/tb_cg_thread_switch.sv
module tb_cg_thread_switch;
  localparam int NT = 4, PC_W = 32, PD = 5, CW = 16;
  localparam logic [31:0] RPC = 32'h100;

  logic clk = 0, rst_n = 0, long_stall = 0;
  logic [PC_W-1:0] stall_pc = '0;
  logic [NT-1:0] miss_done = '0;
  logic fetch_en, redirect, flush, refill_busy;
  logic [1:0] cur_tid;
  logic [PC_W-1:0] redirect_pc;
  logic [CW-1:0] switch_count;

  int checks = 0, fails = 0;
  logic [35:0] expq[$];

  always #5 clk = ~clk;

  cg_thread_switch #(.NT(NT), .PC_W(PC_W), .PIPE_DEPTH(PD), .CNT_W(CW), .RESET_PC(RPC)) dut (
    .clk(clk), .rst_n(rst_n), .long_stall(long_stall), .stall_pc(stall_pc),
    .miss_done(miss_done), .fetch_en(fetch_en), .cur_tid(cur_tid), .redirect(redirect),
    .redirect_pc(redirect_pc), .flush(flush), .refill_busy(refill_busy),
    .switch_count(switch_count));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(bit f, bit r, logic [1:0] tid, logic [31:0] pc);
    expq.push_back({f, r, tid, pc});
  endtask

  always @(negedge clk) begin
    if (rst_n && (flush || redirect)) begin
      logic [35:0] got, exp;
      got = {flush, redirect, cur_tid, redirect ? redirect_pc : 32'h0};
      if (expq.size() == 0) begin
        chk(0, "R2 R7 R8", "unexpected event", got, 0);
      end else begin
        exp = expq.pop_front();
        if (!exp[34]) exp[31:0] = 32'h0;
        chk(got == exp, "R2 R3 R6 R7 R8", "event {flush,redir,tid,pc}", got, exp);
      end
    end
  end

  task automatic stall(logic [31:0] pc);
    @(negedge clk); long_stall = 1; stall_pc = pc;
    @(negedge clk); long_stall = 0;
  endtask

  task automatic ret(int t);
    @(negedge clk); miss_done[t] = 1;
    @(negedge clk); miss_done[t] = 0;
  endtask

  task automatic measure_refill(bit inj, logic [31:0] pc);
    int n = 0;
    while (refill_busy) begin
      if (inj && n == 1) begin long_stall = 1; stall_pc = pc; end
      if (inj && n == 2) long_stall = 0;
      n++;
      @(negedge clk);
    end
    chk(n == PD, "R4", "refill length", n, PD);
    if (inj) begin
      chk(flush == 0, "R5", "no flush in first free cycle", flush, 0);
      @(negedge clk);
      chk(flush == 1, "R5", "held stall flush", flush, 1);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    chk(0, "WATCHDOG", "timeout", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(fetch_en == 1, "R1", "fetch_en", fetch_en, 1);
    chk(cur_tid == 0, "R1", "cur_tid", cur_tid, 0);
    chk(refill_busy == 0, "R1", "refill_busy", refill_busy, 0);
    chk(flush == 0 && redirect == 0, "R1", "pulses", {flush, redirect}, 0);
    chk(switch_count == 0, "R1", "switch_count", switch_count, 0);

    // R2: thread0 -> thread1 at reset PC
    expect_ev(1, 1, 1, RPC);
    stall(32'hA0);
    chk(switch_count == 1, "R2", "count after first switch", switch_count, 1);
    // R5: thread1 stalls during refill -> thread2
    expect_ev(1, 1, 2, RPC);
    measure_refill(1, 32'hB1);
    measure_refill(0, 0);
    // thread2 -> thread3
    expect_ev(1, 1, 3, RPC);
    stall(32'hC2);
    measure_refill(0, 0);
    // R7: thread3 stalls, nobody ready
    expect_ev(1, 0, 3, 0);
    stall(32'hD3);
    chk(fetch_en == 0, "R7", "fetch_en idle", fetch_en, 0);
    stall(32'hEE);
    repeat (3) @(negedge clk);
    chk(switch_count == 4, "R7", "count while idle", switch_count, 4);
    chk(fetch_en == 0, "R7", "still idle", fetch_en, 0);
    // R8: thread1 returns, resume at its saved PC (R3)
    expect_ev(0, 1, 1, 32'hB1);
    @(negedge clk); miss_done[1] = 1;
    @(negedge clk); miss_done[1] = 0;
    chk(fetch_en == 0, "R8", "not yet resumed", fetch_en, 0);
    @(negedge clk);
    chk(fetch_en == 1 && cur_tid == 1, "R8", "resumed {en,tid}", {fetch_en, cur_tid}, 3'b101);
    chk(switch_count == 4, "R8", "resume does not count", switch_count, 4);
    measure_refill(0, 0);
    // R6: thread0 ready, 2 and 3 waiting -> skip to thread0
    ret(0);
    expect_ev(1, 1, 0, 32'hA0);
    stall(32'h1B0);
    measure_refill(0, 0);
    // R6: 2 and 3 ready, 1 waiting -> thread2 at its saved PC
    ret(3);
    ret(2);
    expect_ev(1, 1, 2, 32'hC2);
    stall(32'hA4);
    measure_refill(0, 0);
    chk(switch_count == 6, "R2", "final count", switch_count, 6);
    chk(expq.size() == 0, "R2", "missing events", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule